// File: doc/BRIEF.md
# Shared-Y Multiply / Multiply-Step / Divide Unit

This block is the integer multiply and divide engine of a 32-bit core. It holds a Y register that stores the upper half of every 64-bit product and supplies the upper half of every 64-bit dividend. Full 32×32 multiplies (unsigned and signed) and a single multiply-step complete in the cycle after `start`. The 64/32 divides, unsigned and signed, run iteratively and produce one quotient bit per cycle. The condition codes N, Z, V and C are recomputed for each operation.

An operation is requested by pulsing `start` with an opcode and operands. A one-cycle `done` pulse marks the moment `result`, `y_out` and `cc_out` hold the new values. A divide keeps `busy` high while it iterates. Any `start` that arrives while `busy` is high is dropped. A divide whose quotient cannot be represented in 32 bits returns a saturated value and raises V. A zero divisor is reported through `div_zero` and leaves the visible state as it was.

The multiply-step takes the current N and V from the core's condition codes through `n_in` and `v_in`. Y is written by the load-Y opcode.

Top module: `mdu_unit`

## Requirements
- R1: After synchronous reset, `result`, `y_out`, `cc_out`, `busy`, `done` and `div_zero` are all zero.
- R2: Opcode 0 (unsigned multiply) makes `result` the low 32 bits of a×b and Y the high 32 bits. `done` is high in the cycle after `start`. `cc_out` = {N,Z,V,C} (bit 3 down to bit 0), with N = result[31], Z = (result==0), V = C = 0.
- R3: Opcode 1 (signed multiply) does the same as R2 on the two's-complement product of a and b.
- R4: Opcode 2 (multiply-step) forms op1 = {n_in^v_in, a[31:1]} and an addend equal to b if Y[0] is 1, else 0. `result` = op1 + addend. N, Z, V and C follow the usual add rules. Y becomes {a[0], Y[31:1]}. `done` is high in the next cycle.
- R5: Opcode 5 (load Y) copies a into Y, leaves `result` and `cc_out` unchanged, and pulses `done` in the next cycle.
- R6: Opcode 3 (unsigned divide) returns floor({Y,a}/b). A quotient above 0xFFFFFFFF returns 0xFFFFFFFF with V=1.
- R7: Opcode 4 (signed divide) returns {Y,a}/b truncated toward zero. A quotient outside the signed 32-bit range returns all ones if it is negative, and zero if it is positive, with V=1.
- R8: A divide sets N and Z from `result`, V from overflow and C to 0. It leaves Y unchanged.
- R9: With a non-zero divisor and `start` sampled at edge k, `busy` is high after edges k through k+63. `done` is high only after edge k+64, the same edge at which `busy` falls.
- R10: A divide with b = 0 sets `div_zero` and pulses `done` in the cycle after `start`. `busy` stays low, and `result`, Y and `cc_out` do not change.
- R11: A `start` while `busy` is high is ignored. A `start` with opcode 6 or 7 is ignored: no `done`, and no change to `result` or Y.
- R12: `div_zero` stays set until the next accepted `start` with opcode 0 to 5, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse for one operation |
| op | input | 3 | Opcode: 0 umul, 1 smul, 2 mstep, 3 udiv, 4 sdiv, 5 load Y |
| a | input | 32 | First operand, low dividend half, or new Y value |
| b | input | 32 | Second operand or divisor |
| n_in | input | 1 | Current N flag, used by multiply-step |
| v_in | input | 1 | Current V flag, used by multiply-step |
| result | output | 32 | Result of the last completed operation |
| y_out | output | 32 | Current Y register |
| cc_out | output | 4 | {N,Z,V,C} of the last flag-producing operation |
| busy | output | 1 | Divide iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last accepted divide had a zero divisor |

## Verification
A corrupted partial remainder or quotient bit stays hidden for up to 64 cycles. It only shows when `done` rises, as a wrong `result` or a wrong V. For that reason the divides are checked against an independent 64-bit reference over many dividend/divisor mixes, including both saturation edges and the exact -2^31 fit. A miscounted iteration counter shows at once as `done` in the wrong cycle, or as `busy` dropping early. The bench observes both of these on every divide. Y errors from the multiply-step carry into the next operation that reads Y, so every operation's Y is compared right after its own `done`.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_UMUL  = 3'd0,
        OP_SMUL  = 3'd1,
        OP_MSTEP = 3'd2,
        OP_UDIV  = 3'd3,
        OP_SDIV  = 3'd4,
        OP_LOADY = 3'd5
    } mdu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    function automatic logic op_is_div(input logic [2:0] opc);
        return (opc == OP_UDIV) || (opc == OP_SDIV);
    endfunction

    function automatic logic op_is_known(input logic [2:0] opc);
        return opc <= 3'd5;
    endfunction

    function automatic cc_t cc_make(input logic n, input logic z,
                                    input logic v, input logic c);
        cc_t r;
        r.n = n;
        r.z = z;
        r.v = v;
        r.c = c;
        return r;
    endfunction

endpackage

// File: rtl/mdu_mult.sv
module mdu_mult #(
    parameter int unsigned W = 32
) (
    input  logic         signed_mode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    localparam int unsigned DW = 2 * W;

    logic [DW-1:0] prod_u;
    logic [W-1:0]  fix_a;
    logic [W-1:0]  fix_b;

    // Unsigned product, then two's-complement correction of the high half.
    always_comb begin
        prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        fix_a  = (signed_mode && a[W-1]) ? b : '0;
        fix_b  = (signed_mode && b[W-1]) ? a : '0;
        lo     = prod_u[W-1:0];
        hi     = prod_u[DW-1:W] - fix_a - fix_b;
    end

endmodule

// File: rtl/mdu_mstep.sv
module mdu_mstep
    import mdu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         n_in,
    input  logic         v_in,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum,
    output logic [W-1:0] y_next,
    output cc_t          cc
);
    logic [W-1:0] op1;
    logic [W-1:0] addend;
    logic [W:0]   wide;
    logic         ovf;

    always_comb begin
        op1    = {n_in ^ v_in, a[W-1:1]};
        addend = y[0] ? b : '0;
        wide   = {1'b0, op1} + {1'b0, addend};
        sum    = wide[W-1:0];
        ovf    = (op1[W-1] == addend[W-1]) && (wide[W-1] != op1[W-1]);
        cc     = cc_make(wide[W-1], (wide[W-1:0] == '0), ovf, wide[W]);
        y_next = {a[0], y[W-1:1]};
    end

endmodule

// File: rtl/mdu_divider.sv
module mdu_divider #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic         sgn,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] dsr,
    output logic         busy,
    output logic         fin,
    output logic         ovf,
    output logic [W-1:0] quo
);
    localparam int unsigned DW = 2 * W;
    localparam int unsigned CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  dsr_q;
    logic [DW-1:0] dvd_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          neg_q;
    logic          sgn_q;

    logic [DW-1:0] dvd_in;
    logic [W-1:0]  dsr_in;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          ge;
    logic [W-1:0]  rem_nx;
    logic [DW-1:0] dvd_nx;
    logic [DW-1:0] mag_neg;

    // Operand magnitudes for the setup cycle.
    always_comb begin
        dvd_in = {hi, lo};
        if (sgn && hi[W-1]) dvd_in = -{hi, lo};
        dsr_in = dsr;
        if (sgn && dsr[W-1]) dsr_in = -dsr;
    end

    // One restoring step per cycle.
    always_comb begin
        trial  = {rem_q, dvd_q[DW-1]};
        diff   = trial - {1'b0, dsr_q};
        ge     = (trial >= {1'b0, dsr_q});
        rem_nx = ge ? diff[W-1:0] : trial[W-1:0];
        dvd_nx = {dvd_q[DW-2:0], ge};
    end

    // Final sign and saturation applied to the last quotient.
    always_comb begin
        mag_neg = -dvd_nx;
        if (!sgn_q) begin
            ovf = |dvd_nx[DW-1:W];
            quo = ovf ? '1 : dvd_nx[W-1:0];
        end else if (!neg_q) begin
            ovf = |dvd_nx[DW-1:W-1];
            quo = ovf ? '0 : dvd_nx[W-1:0];
        end else begin
            ovf = (|dvd_nx[DW-1:W]) || (dvd_nx[W-1] && (|dvd_nx[W-2:0]));
            quo = ovf ? '1 : mag_neg[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            dsr_q  <= '0;
            dvd_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            neg_q  <= 1'b0;
            sgn_q  <= 1'b0;
        end else if (go) begin
            rem_q  <= '0;
            dsr_q  <= dsr_in;
            dvd_q  <= dvd_in;
            cnt_q  <= '0;
            busy_q <= 1'b1;
            sgn_q  <= sgn;
            neg_q  <= sgn && (hi[W-1] ^ dsr[W-1]);
        end else if (busy_q) begin
            rem_q <= rem_nx;
            dvd_q <= dvd_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) busy_q <= 1'b0;
        end
    end

    assign busy = busy_q;
    assign fin  = busy_q && (cnt_q == LAST);

    // R11: a new divide is only launched while idle.
    p_go_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy_q);

    // R9: the counter restarts at zero on every launch.
    p_cnt_restart_r9: assert property (@(posedge clk) disable iff (rst)
        go |=> (busy_q && cnt_q == '0));

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
    import mdu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         n_in,
    input  logic         v_in,
    output logic [W-1:0] result,
    output logic [W-1:0] y_out,
    output logic [3:0]   cc_out,
    output logic         busy,
    output logic         done,
    output logic         div_zero
);
    logic [W-1:0] res_q;
    logic [W-1:0] y_q;
    cc_t          cc_q;
    logic         done_q;
    logic         dz_q;

    logic         accept;
    logic         b_zero;
    logic         div_go;
    mdu_op_e      op_e;

    logic [W-1:0] mul_lo;
    logic [W-1:0] mul_hi;
    logic [W-1:0] ms_sum;
    logic [W-1:0] ms_y;
    cc_t          ms_cc;
    logic         dv_busy;
    logic         dv_fin;
    logic         dv_ovf;
    logic [W-1:0] dv_quo;

    assign op_e   = mdu_op_e'(op);
    assign b_zero = (b == '0);
    assign accept = start && !dv_busy && op_is_known(op);
    assign div_go = accept && op_is_div(op) && !b_zero;

    mdu_mult #(.W(W)) u_mult (
        .signed_mode (op_e == OP_SMUL),
        .a           (a),
        .b           (b),
        .lo          (mul_lo),
        .hi          (mul_hi)
    );

    mdu_mstep #(.W(W)) u_mstep (
        .n_in   (n_in),
        .v_in   (v_in),
        .a      (a),
        .b      (b),
        .y      (y_q),
        .sum    (ms_sum),
        .y_next (ms_y),
        .cc     (ms_cc)
    );

    mdu_divider #(.W(W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .sgn  (op_e == OP_SDIV),
        .hi   (y_q),
        .lo   (a),
        .dsr  (b),
        .busy (dv_busy),
        .fin  (dv_fin),
        .ovf  (dv_ovf),
        .quo  (dv_quo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            y_q    <= '0;
            cc_q   <= '0;
            done_q <= 1'b0;
            dz_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (dv_fin) begin
                res_q  <= dv_quo;
                cc_q   <= cc_make(dv_quo[W-1], (dv_quo == '0), dv_ovf, 1'b0);
                done_q <= 1'b1;
            end else if (accept) begin
                dz_q <= 1'b0;
                case (op_e)
                    OP_UMUL, OP_SMUL: begin
                        res_q  <= mul_lo;
                        y_q    <= mul_hi;
                        cc_q   <= cc_make(mul_lo[W-1], (mul_lo == '0), 1'b0, 1'b0);
                        done_q <= 1'b1;
                    end
                    OP_MSTEP: begin
                        res_q  <= ms_sum;
                        y_q    <= ms_y;
                        cc_q   <= ms_cc;
                        done_q <= 1'b1;
                    end
                    OP_LOADY: begin
                        y_q    <= a;
                        done_q <= 1'b1;
                    end
                    OP_UDIV, OP_SDIV: begin
                        if (b_zero) begin
                            dz_q   <= 1'b1;
                            done_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign result   = res_q;
    assign y_out    = y_q;
    assign cc_out   = cc_q;
    assign busy     = dv_busy;
    assign done     = done_q;
    assign div_zero = dz_q;

    // R9: completion never overlaps an iteration.
    p_no_done_while_busy_r9: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R9: the end of an iteration run is the completion cycle.
    p_fall_is_done_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R8: a divide never touches Y.
    p_y_hold_div_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(y_out));

    // R8: an iterated divide always clears C.
    p_div_c_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (done && $past(busy)) |-> !cc_out[0]);

    // R10: a zero-divisor report completes at once, without iterating.
    p_dz_immediate_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(div_zero) |-> (done && !busy));

endmodule

// File: tb/mdu_unit_test.sv
`timescale 1ns/1ps
module mdu_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        n_in = 1'b0;
    logic        v_in = 1'b0;
    logic [31:0] result;
    logic [31:0] y_out;
    logic [3:0]  cc_out;
    logic        busy;
    logic        done;
    logic        div_zero;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_res = '0;
    logic [31:0] m_y = '0;
    logic [3:0]  m_cc = '0;
    logic        m_dz = 1'b0;

    always #2.5 clk = ~clk;

    mdu_unit uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .a(a), .b(b),
        .n_in(n_in), .v_in(v_in), .result(result), .y_out(y_out),
        .cc_out(cc_out), .busy(busy), .done(done), .div_zero(div_zero)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] flags_of(input logic [31:0] r, input logic v);
        return {r[31], (r == 32'd0), v, 1'b0};
    endfunction

    // Apply one operation, compute its expected outcome, check it.
    // inj > 0: during a divide, also pulse start (umul) at that busy cycle.
    task automatic run_op(input logic [2:0] opc, input logic [31:0] av,
                          input logic [31:0] bv, input logic nv, input logic vv,
                          input int inj);
        logic [31:0] e_res;
        logic [31:0] e_y;
        logic [3:0]  e_cc;
        logic        e_dz;
        logic        e_done;
        bit          slow;
        bit          lat_bad;
        string       tag;
        longint unsigned pu;
        longint          ps;
        longint unsigned xu;
        longint unsigned qu;
        longint          sx;
        longint          sb;
        longint          qs;
        logic [31:0] op1;
        logic [31:0] add;
        logic [32:0] wsum;
        e_res = m_res; e_y = m_y; e_cc = m_cc; e_dz = 1'b0; e_done = 1'b1;
        slow = 0; lat_bad = 0; tag = "R11";
        case (opc)
            3'd0: begin
                tag = "R2";
                pu = longint'(av) * longint'(bv);
                e_res = pu[31:0]; e_y = pu[63:32]; e_cc = flags_of(e_res, 1'b0);
            end
            3'd1: begin
                tag = "R3";
                ps = longint'($signed(av)) * longint'($signed(bv));
                e_res = ps[31:0]; e_y = ps[63:32]; e_cc = flags_of(e_res, 1'b0);
            end
            3'd2: begin
                tag = "R4";
                op1 = {nv ^ vv, av[31:1]};
                add = m_y[0] ? bv : 32'd0;
                wsum = {1'b0, op1} + {1'b0, add};
                e_res = wsum[31:0];
                e_cc = {wsum[31], (wsum[31:0] == 32'd0),
                        (op1[31] == add[31]) && (wsum[31] != op1[31]), wsum[32]};
                e_y = {av[0], m_y[31:1]};
            end
            3'd5: begin
                tag = "R5";
                e_y = av;
            end
            3'd3, 3'd4: begin
                tag = (opc == 3'd3) ? "R6" : "R7";
                if (bv == 32'd0) begin
                    tag = "R10";
                    e_dz = 1'b1;
                end else begin
                    slow = 1;
                    if (opc == 3'd3) begin
                        xu = {m_y, av};
                        qu = xu / {32'd0, bv};
                        if (qu > 64'h0000_0000_FFFF_FFFF) begin
                            e_res = 32'hFFFF_FFFF; e_cc = flags_of(e_res, 1'b1);
                        end else begin
                            e_res = qu[31:0]; e_cc = flags_of(e_res, 1'b0);
                        end
                    end else begin
                        sx = $signed({m_y, av});
                        sb = longint'($signed(bv));
                        qs = sx / sb;
                        if (qs > 64'sd2147483647 || qs < -64'sd2147483648) begin
                            e_res = (qs < 0) ? 32'hFFFF_FFFF : 32'd0;
                            e_cc = flags_of(e_res, 1'b1);
                        end else begin
                            e_res = qs[31:0]; e_cc = flags_of(e_res, 1'b0);
                        end
                    end
                end
            end
            default: begin
                e_done = 1'b0;
                e_dz = m_dz;
            end
        endcase

        @(negedge clk);
        start = 1'b1; op = opc; a = av; b = bv; n_in = nv; v_in = vv;
        @(negedge clk);
        start = 1'b0;
        if (slow) begin
            for (int j = 1; j <= 63; j++) begin
                if (!busy || done) lat_bad = 1;
                if (inj > 0 && j == inj) begin
                    start = 1'b1; op = 3'd0; a = 32'h1234_5678; b = 32'h9;
                end
                @(negedge clk);
                if (inj > 0 && j == inj) start = 1'b0;
            end
            if (!busy || done) lat_bad = 1;
            @(negedge clk);
            chk("R9", "latency window", {63'd0, lat_bad}, 64'd0);
            chk("R9", "busy after last step", {63'd0, busy}, 64'd0);
            if (inj > 0) chk("R11", "start while busy dropped", {32'd0, result}, {32'd0, e_res});
        end else if (opc == 3'd3 || opc == 3'd4) begin
            chk("R10", "busy on zero divisor", {63'd0, busy}, 64'd0);
        end
        chk(tag, "done", {63'd0, done}, {63'd0, e_done});
        chk(tag, "result", {32'd0, result}, {32'd0, e_res});
        chk((opc == 3'd3 || opc == 3'd4) ? "R8" : tag, "y", {32'd0, y_out}, {32'd0, e_y});
        chk((opc == 3'd3 || opc == 3'd4) ? "R8" : tag, "cc", {60'd0, cc_out}, {60'd0, e_cc});
        chk(e_dz ? "R10" : "R12", "div_zero", {63'd0, div_zero}, {63'd0, e_dz});
        m_res = e_res; m_y = e_y; m_cc = e_cc; m_dz = e_dz;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] ra;
        logic [31:0] rb;
        logic [31:0] ry;
        logic [31:0] seed;
        seed = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        chk("R1", "result", {32'd0, result}, 64'd0);
        chk("R1", "y", {32'd0, y_out}, 64'd0);
        chk("R1", "cc", {60'd0, cc_out}, 64'd0);
        chk("R1", "busy/done/dz", {61'd0, busy, done, div_zero}, 64'd0);

        // R2 / R3 directed
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
        run_op(3'd0, 32'd0, 32'h1234_0000, 0, 0, 0);
        run_op(3'd1, 32'hFFFF_FFFF, 32'd1, 0, 0, 0);
        run_op(3'd1, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
        // R5, R4 directed: addend used / not used, N^V inserted, overflow
        run_op(3'd5, 32'h0000_0001, 32'd0, 0, 0, 0);
        run_op(3'd2, 32'hFFFF_FFFE, 32'h7FFF_FFFF, 1, 0, 0);
        run_op(3'd2, 32'h0000_0003, 32'h0000_0005, 1, 1, 0);
        run_op(3'd5, 32'h0000_0001, 32'd0, 0, 0, 0);
        run_op(3'd2, 32'hFFFF_FFFF, 32'h4000_0000, 0, 0, 0);
        // R6 directed
        run_op(3'd5, 32'd0, 32'd0, 0, 0, 0);
        run_op(3'd3, 32'd100, 32'd7, 0, 0, 0);
        run_op(3'd5, 32'd5, 32'd0, 0, 0, 0);
        run_op(3'd3, 32'd0, 32'd2, 0, 0, 0);
        run_op(3'd5, 32'd0, 32'd0, 0, 0, 0);
        run_op(3'd3, 32'd3, 32'd7, 0, 0, 0);
        // R7 directed: truncation, both saturation edges, exact -2^31
        run_op(3'd5, 32'hFFFF_FFFF, 32'd0, 0, 0, 0);
        run_op(3'd4, 32'hFFFF_FF9C, 32'd7, 0, 0, 0);
        run_op(3'd5, 32'd0, 32'd0, 0, 0, 0);
        run_op(3'd4, 32'h8000_0000, 32'd1, 0, 0, 0);
        run_op(3'd5, 32'd0, 32'd0, 0, 0, 0);
        run_op(3'd4, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0);
        run_op(3'd5, 32'd1, 32'd0, 0, 0, 0);
        run_op(3'd4, 32'd0, 32'hFFFF_FFFF, 0, 0, 0);
        // R10 zero divisor, then R12 clear
        run_op(3'd5, 32'h0000_0123, 32'd0, 0, 0, 0);
        run_op(3'd3, 32'd55, 32'd0, 0, 0, 0);
        run_op(3'd4, 32'd55, 32'd0, 0, 0, 0);
        run_op(3'd7, 32'd1, 32'd1, 0, 0, 0);
        run_op(3'd0, 32'd6, 32'd7, 0, 0, 0);
        // R11 ignored opcodes and start while busy
        run_op(3'd6, 32'hDEAD_BEEF, 32'd3, 0, 0, 0);
        run_op(3'd5, 32'd0, 32'd0, 0, 0, 0);
        run_op(3'd3, 32'h0000_1000, 32'd16, 0, 0, 5);

        // Random mix
        for (int i = 0; i < 30; i++) begin
            ra = $urandom; rb = $urandom;
            run_op(3'd0, ra, rb, 0, 0, 0);
            ra = $urandom; rb = $urandom;
            run_op(3'd1, ra, rb, 0, 0, 0);
            ra = $urandom; rb = $urandom;
            run_op(3'd2, ra, rb, 1'($urandom), 1'($urandom), 0);
            rb = $urandom;
            if (rb == 32'd0) rb = 32'd1;
            ry = $urandom;
            if (i % 2 == 0) ry = ry % rb;
            run_op(3'd5, ry, 32'd0, 0, 0, 0);
            run_op(3'd3, $urandom, rb, 0, 0, 0);
            rb = $urandom;
            if (rb == 32'd0 || rb == 32'hFFFF_FFFF) rb = 32'd3;
            ry = $urandom;
            if (i % 2 == 0) ry = {32{ry[0]}};
            run_op(3'd5, ry, 32'd0, 0, 0, 0);
            run_op(3'd4, $urandom, rb, 0, 0, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule